// File: doc/BRIEF.md
# GPIO Channel with Per-Pin Interrupt Detection

This block is one general-purpose I/O channel of up to sixteen pins behind a 32-bit register interface. Words are addressed by index. For each pin, software sets the value to drive, sets whether the pin drives at all, and reads back the synchronised pin level. Each pin also has its own interrupt detector. Software picks one of five trigger conditions for it, enables it, and masks it. A latched status bit records each trigger and is acknowledged by writing a one. The channel raises one interrupt line while any enabled, unmasked status bit is set.

Pin inputs pass through a two-flop synchroniser. A detector compares the synchronised level with the level it held on the previous cycle. A small state machine runs the soft reset. In state `SR_RUN` the channel works normally. Writing 1 to the soft-reset word takes transition `T_ENTER` into state `SR_HOLD`. In that state every register, synchroniser and detector is held at its reset value. Writing 0 to the same word takes transition `T_LEAVE` back to `SR_RUN`. Any other bus activity leaves the state unchanged (`T_STAY`).

Top module: `gpio_irq_port`

## Requirements
- R1: After `rst_n` is released, every readable word reads zero, except the pin-level word, which follows the pins. `pin_oe`, `pin_out` and `irq` are low. Every trigger code is 0 (falling edge).
- R2: Word 6 holds the output values and drives `pin_out`. Word 8 holds the direction, where bit 1 means the pin drives, and it drives `pin_oe`. Both words read back what was written.
- R3: Word 7 returns the pin levels after a two-flop synchroniser. A pin change made between two clock edges appears in word 7 after the second of the next two edges, and not after the first.
- R4: Each pin has a 3-bit trigger code: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 either edge. Codes 5 to 7 never trigger. Pin n keeps its code in bits [4m+2:4m], where m = n mod 8. Pins 0 to 7 use word 9 and pins 8 to 15 use word 10. Bit 3 of each nibble reads zero.
- R5: In an edge mode, a status bit (word 1) is set by a matching change of the synchronised level. It stays set after the level settles.
- R6: In a level mode, the status bit is set on every cycle that the level matches. When a clear and a trigger fall in the same cycle, the trigger wins, so a held level keeps the status bit set through a clear.
- R7: A status bit can only become set while its enable bit (word 0) is 1.
- R8: Writing 1 to a bit of word 3 clears that status bit. Bits written as 0 have no effect. Writes to word 1 are ignored.
- R9: Writing 1 to a bit of word 4 sets that pin's mask bit, and writing 1 to a bit of word 5 clears it. Zero bits change nothing. Word 4 reads back the mask.
- R10: Word 2 reads status AND enable AND NOT mask. `irq` is high exactly when that value is non-zero.
- R11: Bits at or above the pin count read as zero in every word other than words 9 and 10.
- R12: Word 12, bit 0, is the soft reset. While it is 1, word 12 reads 1. All other registers return to their R1 values and ignore writes. Writing 0 releases the channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Word index for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | PINS | Pin levels, asynchronous |
| pin_out | output | PINS | Output values |
| pin_oe | output | PINS | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench steps each trigger code through matching and non-matching level pairs, on pins in both mode words and at the nibble ends. A misplaced nibble would therefore trigger the wrong pin or none at all. It clears a status bit while a high level is held: a design that let the clear win would drop an interrupt that is still pending. If a clear took effect without a written 1, or writes to the raw status word were not ignored, the edge status would be lost early. The bench also checks the synchroniser latency one cycle early, the truncation of upper bits, and that writes are locked out during soft reset, each of which a careless register file would get wrong.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int CODE_W   = 3;
    localparam int NIB_W    = 4;
    localparam int PER_WORD = DATA_W / NIB_W;

    typedef enum logic [CODE_W-1:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

    typedef enum logic [ADDR_W-1:0] {
        W_EN    = 4'd0,
        W_STAT  = 4'd1,
        W_DISP  = 4'd2,
        W_CLR   = 4'd3,
        W_MSET  = 4'd4,
        W_MCLR  = 4'd5,
        W_POUT  = 4'd6,
        W_PIN   = 4'd7,
        W_PDIR  = 4'd8,
        W_MODE0 = 4'd9,
        W_MODE1 = 4'd10,
        W_RSVD  = 4'd11,
        W_SRST  = 4'd12
    } word_e;

    typedef enum logic {
        SR_RUN  = 1'b0,
        SR_HOLD = 1'b1
    } srst_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] safe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            safe_q <= '0;
        end else if (wipe) begin
            meta_q <= '0;
            safe_q <= '0;
        end else begin
            meta_q <= d;
            safe_q <= meta_q;
        end
    end

    assign q = safe_q;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wipe, 2) && !$past(wipe) |-> q == $past(d, 2)) // R3
        else $error("synchroniser latency broken");

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              en_i,
    input  logic [CODE_W-1:0] mode_i,
    input  logic              clr_i,
    input  logic              lvl_i,
    output logic              stat_o
);
    logic prev_q;
    logic stat_q;
    logic hit;

    always_comb begin
        unique case (mode_i)
            TRIG_FALL: hit = prev_q & ~lvl_i;
            TRIG_RISE: hit = ~prev_q & lvl_i;
            TRIG_LOW:  hit = ~lvl_i;
            TRIG_HIGH: hit = lvl_i;
            TRIG_BOTH: hit = prev_q ^ lvl_i;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
        end else if (wipe) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            stat_q <= (stat_q & ~clr_i) | (en_i & hit);
        end
    end

    assign stat_o = stat_q;

    AST_EN_GATES_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o) |-> $past(en_i)) // R7
        else $error("status set without enable");

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) && !$past(en_i) |-> !stat_o) // R8
        else $error("clear did not take");

    AST_LEVEL_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i) && !$past(wipe) && $past(mode_i) == TRIG_HIGH && $past(lvl_i)
        |-> stat_o) // R6
        else $error("held high level lost");

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    localparam int MODE_WORDS = (PINS + PER_WORD - 1) / PER_WORD;

    srst_e             state_q, state_d;
    logic              hold;
    logic [PINS-1:0]   en_q, mask_q, pout_q, pdir_q;
    logic [CODE_W-1:0] mode_q [PINS];
    logic [PINS-1:0]   pin_sync, stat, disp, clr_vec;
    logic [DATA_W-1:0] mode_w0, mode_w1;
    logic              wr_ok;

    // soft reset state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_RUN;
        else        state_q <= state_d;
    end

    // transitions: T_ENTER, T_LEAVE, T_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_RUN:  if (bus_wr && bus_addr == W_SRST && bus_wdata[0])  state_d = SR_HOLD;
            SR_HOLD: if (bus_wr && bus_addr == W_SRST && !bus_wdata[0]) state_d = SR_RUN;
            default: state_d = SR_RUN;
        endcase
    end

    // state outputs
    always_comb begin
        hold  = (state_q == SR_HOLD);
        wr_ok = bus_wr && (state_q == SR_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            pout_q <= '0;
            pdir_q <= '0;
            for (int n = 0; n < PINS; n++) mode_q[n] <= '0;
        end else if (hold) begin
            en_q   <= '0;
            mask_q <= '0;
            pout_q <= '0;
            pdir_q <= '0;
            for (int n = 0; n < PINS; n++) mode_q[n] <= '0;
        end else if (wr_ok) begin
            unique case (bus_addr)
                W_EN:    en_q   <= bus_wdata[PINS-1:0];
                W_MSET:  mask_q <= mask_q | bus_wdata[PINS-1:0];
                W_MCLR:  mask_q <= mask_q & ~bus_wdata[PINS-1:0];
                W_POUT:  pout_q <= bus_wdata[PINS-1:0];
                W_PDIR:  pdir_q <= bus_wdata[PINS-1:0];
                W_MODE0: for (int n = 0; n < PINS; n++)
                             if (n < PER_WORD) mode_q[n] <= bus_wdata[(n%PER_WORD)*NIB_W +: CODE_W];
                W_MODE1: for (int n = 0; n < PINS; n++)
                             if (n >= PER_WORD) mode_q[n] <= bus_wdata[(n%PER_WORD)*NIB_W +: CODE_W];
                default: ;
            endcase
        end
    end

    assign clr_vec = (wr_ok && bus_addr == W_CLR) ? bus_wdata[PINS-1:0] : '0;

    gpio_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .wipe  (hold),
        .d     (pin_in),
        .q     (pin_sync)
    );

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        gpio_pin_detect u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .wipe   (hold),
            .en_i   (en_q[g]),
            .mode_i (mode_q[g]),
            .clr_i  (clr_vec[g]),
            .lvl_i  (pin_sync[g]),
            .stat_o (stat[g])
        );
    end

    always_comb begin
        mode_w0 = '0;
        mode_w1 = '0;
        for (int n = 0; n < PINS; n++) begin
            if (n < PER_WORD) mode_w0[(n%PER_WORD)*NIB_W +: CODE_W] = mode_q[n];
            else              mode_w1[(n%PER_WORD)*NIB_W +: CODE_W] = mode_q[n];
        end
    end

    assign disp    = stat & en_q & ~mask_q;
    assign irq     = |disp;
    assign pin_out = pout_q;
    assign pin_oe  = pdir_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            W_EN:    bus_rdata[PINS-1:0] = en_q;
            W_STAT:  bus_rdata[PINS-1:0] = stat;
            W_DISP:  bus_rdata[PINS-1:0] = disp;
            W_MSET:  bus_rdata[PINS-1:0] = mask_q;
            W_POUT:  bus_rdata[PINS-1:0] = pout_q;
            W_PIN:   bus_rdata[PINS-1:0] = pin_sync;
            W_PDIR:  bus_rdata[PINS-1:0] = pdir_q;
            W_MODE0: bus_rdata = mode_w0;
            W_MODE1: bus_rdata = (MODE_WORDS > 1) ? mode_w1 : '0;
            W_SRST:  bus_rdata[0] = hold;
            default: bus_rdata = '0;
        endcase
    end

    AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q & ~mask_q) != '0) // R10
        else $error("irq with nothing unmasked");

    AST_HOLD_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) && hold |-> pin_oe == '0 && pin_out == '0 && !irq) // R12
        else $error("soft reset not holding defaults");

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr != W_MODE0 && bus_addr != W_MODE1 |-> (bus_rdata >> PINS) == '0) // R11
        else $error("unimplemented bits read non-zero");

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == W_MSET && !hold
        |=> (mask_q & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])) // R9
        else $error("mask set lost");

endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
    localparam int PINS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out, pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    gpio_irq_port #(.PINS(PINS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // pin, trigger code, level before, level after, expected status
    typedef struct packed {
        logic [3:0] pin;
        logic [2:0] code;
        logic       l0;
        logic       l1;
        logic       ex;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{4'd0,  3'd0, 1'b1, 1'b0, 1'b1},
        '{4'd1,  3'd0, 1'b0, 1'b1, 1'b0},
        '{4'd2,  3'd1, 1'b0, 1'b1, 1'b1},
        '{4'd3,  3'd1, 1'b1, 1'b0, 1'b0},
        '{4'd4,  3'd4, 1'b1, 1'b0, 1'b1},
        '{4'd5,  3'd4, 1'b0, 1'b1, 1'b1},
        '{4'd6,  3'd4, 1'b1, 1'b1, 1'b0},
        '{4'd9,  3'd2, 1'b1, 1'b0, 1'b1},
        '{4'd10, 3'd2, 1'b1, 1'b1, 1'b0},
        '{4'd11, 3'd3, 1'b0, 1'b1, 1'b1},
        '{4'd12, 3'd3, 1'b0, 1'b0, 1'b0},
        '{4'd15, 3'd5, 1'b0, 1'b1, 1'b0},
        '{4'd8,  3'd1, 1'b0, 1'b1, 1'b1},
        '{4'd7,  3'd0, 1'b1, 1'b0, 1'b1}
    };

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic soft_reset();
        wr(4'd12, 32'd1);
        wr(4'd12, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a <= 12; a++) begin
            rd(a[3:0], rv);
            chk($sformatf("R1 word %0d", a), rv, 32'd0);
        end
        chk("R1 pin_oe/pin_out/irq", {pin_oe, pin_out, 31'd0, irq}, '0);

        // R2: output and direction
        wr(4'd6, 32'h1234_A5A5);
        wr(4'd8, 32'h0000_00FF);
        rd(4'd6, rv); chk("R2 pout readback", rv, 32'h0000_A5A5);
        chk("R2 pin_out", {16'd0, pin_out}, 32'h0000_A5A5);
        chk("R2 pin_oe", {16'd0, pin_oe}, 32'h0000_00FF);

        // R3: two-stage latency
        @(negedge clk); pin_in = 16'h3C5A;
        rd(4'd7, rv); chk("R3 one edge still old", rv, 32'd0);
        rd(4'd7, rv); chk("R3 after two edges", rv, 32'h0000_3C5A);
        @(negedge clk); pin_in = '0;

        // R11 / R4: truncation of unimplemented bits
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, rv); chk("R11 enable upper bits", rv, 32'h0000_FFFF);
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, rv); chk("R4 mode word 0 nibble bit 3", rv, 32'h7777_7777);
        wr(4'd10, 32'hFFFF_FFFF);
        rd(4'd10, rv); chk("R4 mode word 1 nibble bit 3", rv, 32'h7777_7777);

        // R12: soft reset holds and locks writes
        wr(4'd12, 32'd1);
        rd(4'd12, rv); chk("R12 hold reads 1", rv, 32'd1);
        wr(4'd6, 32'h0000_FFFF);
        rd(4'd6, rv); chk("R12 write ignored in hold", rv, 32'd0);
        wr(4'd12, 32'd0);
        rd(4'd8, rv);  chk("R12 direction cleared", rv, 32'd0);
        rd(4'd0, rv);  chk("R12 enable cleared", rv, 32'd0);
        rd(4'd9, rv);  chk("R12 mode cleared", rv, 32'd0);
        rd(4'd12, rv); chk("R12 released", rv, 32'd0);

        // Vector table: R4 R5 R6 R7
        for (int vi = 0; vi < NV; vi++) begin
            automatic int p = VT[vi].pin;
            automatic logic [31:0] bit_p = 32'd1 << p;
            soft_reset();
            @(negedge clk); pin_in = '0; pin_in[p] = VT[vi].l0;
            repeat (4) @(negedge clk);
            wr((p < 8) ? 4'd9 : 4'd10, {29'd0, VT[vi].code} << ((p % 8) * 4));
            wr(4'd0, bit_p);
            pin_in[p] = VT[vi].l1;
            repeat (4) @(negedge clk);
            rd(4'd1, rv);
            chk($sformatf("R4/R5/R6 vector %0d status", vi), rv, VT[vi].ex ? bit_p : 32'd0);
            rd(4'd2, rv);
            chk($sformatf("R10 vector %0d display", vi), rv, VT[vi].ex ? bit_p : 32'd0);
            chk($sformatf("R10 vector %0d irq", vi), {31'd0, irq}, {31'd0, VT[vi].ex});
        end

        // R9 / R10 / R8: mask and clear on pin 3, rising edge
        soft_reset();
        @(negedge clk); pin_in = '0;
        wr(4'd9, 32'h0000_1000);
        wr(4'd0, 32'h0000_0008);
        pin_in = 16'h0008;
        repeat (4) @(negedge clk);
        chk("R5 edge latched irq", {31'd0, irq}, 32'd1);
        wr(4'd4, 32'd0);
        rd(4'd4, rv); chk("R9 zero mask-set write", rv, 32'd0);
        wr(4'd4, 32'h0000_0008);
        rd(4'd4, rv); chk("R9 mask set", rv, 32'h0000_0008);
        rd(4'd2, rv); chk("R10 masked display", rv, 32'd0);
        chk("R10 masked irq", {31'd0, irq}, 32'd0);
        rd(4'd1, rv); chk("R10 raw status kept under mask", rv, 32'h0000_0008);
        wr(4'd5, 32'd0);
        rd(4'd4, rv); chk("R9 zero mask-clear write", rv, 32'h0000_0008);
        wr(4'd5, 32'h0000_0008);
        chk("R9 unmask restores irq", {31'd0, irq}, 32'd1);
        wr(4'd1, 32'h0000_FFFF);
        rd(4'd1, rv); chk("R8 status word write ignored", rv, 32'h0000_0008);
        wr(4'd3, 32'd0);
        rd(4'd1, rv); chk("R8 zero clear write", rv, 32'h0000_0008);
        wr(4'd3, 32'h0000_0008);
        rd(4'd1, rv); chk("R8 clear edge status", rv, 32'd0);
        chk("R8 irq after clear", {31'd0, irq}, 32'd0);

        // R7: disabled pin does not latch
        wr(4'd0, 32'd0);
        @(negedge clk); pin_in = '0;
        repeat (4) @(negedge clk);
        pin_in = 16'h0008;
        repeat (4) @(negedge clk);
        rd(4'd1, rv); chk("R7 no set while disabled", rv, 32'd0);

        // R6: held high level survives a clear
        wr(4'd9, 32'h0000_3000);
        wr(4'd0, 32'h0000_0008);
        repeat (2) @(negedge clk);
        wr(4'd3, 32'h0000_0008);
        rd(4'd1, rv); chk("R6 level re-fires after clear", rv, 32'h0000_0008);
        @(negedge clk); pin_in = '0;
        repeat (4) @(negedge clk);
        wr(4'd3, 32'h0000_0008);
        rd(4'd1, rv); chk("R6 clear after level drops", rv, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule